// File: doc/BRIEF.md
# Converter Result Readout Serial Slave

This block is the two-wire serial slave that sits in front of a delta-sigma converter's sequencer. It watches the clock and data lines through a two-flop synchronizer running on a faster system clock, finds start, repeated-start and stop conditions, and answers to two 7-bit addresses. One is the converter's own address, which can be read or written. The other is a broadcast address, which answers only writes and is used to start several converters at once. While the sequencer reports a conversion in progress, the slave leaves the data line released when it is addressed, so the master sees a NAK.

A write carries a single configuration byte; its last bit selects the conversion speed. A read returns the converter result, MSB first, as two bytes; the result is latched when the address is acknowledged. The data line is open-drain: the block only raises an output-enable that pulls the line low. Two single-cycle event pulses tell the sequencer when to start the next conversion: one at a stop that closes an acknowledged transaction, and one when the final result bit has been shifted out.

The result bus is a level held by the sequencer and carries no handshake. No back-pressure exists at this edge, because the master sets the pace of every bit.

Top module: `adc_i2c_slave`

## Requirements
- R1: During and after reset `sda_oe_o` is 0, `mode_o` is 0 and neither event pulse fires.
- R2: A start seen in the middle of a byte (SDA falling while SCL is high) abandons that byte and begins a fresh address reception.
- R3: Address 7'b0010100 is acknowledged for both read (eighth bit 1) and write (eighth bit 0): `sda_oe_o` is high throughout the ninth SCL clock.
- R4: The broadcast address 7'b1110111 is acknowledged with the write bit and refused (NAK) with the read bit; an acknowledged broadcast write byte updates `mode_o` like a normal write.
- R5: Any other address is refused: `sda_oe_o` stays low through the ninth clock and for the rest of that transaction.
- R6: While `conv_busy_i` is high at the end of the eighth address bit, a matching address is refused.
- R7: After an acknowledged write address, one data byte is accepted and acknowledged, and its last-received bit (bit 0, sampled on rising SCL) becomes `mode_o`. A second byte in the same transaction is refused and leaves `mode_o` unchanged.
- R8: A stop that arrives before the data byte and its acknowledge have completed leaves `mode_o` unchanged.
- R9: A read returns the 16-bit result captured at the address acknowledge, MSB first. The output-enable changes only after a falling SCL edge, so each bit is stable while SCL is high. Later changes on `result_i` do not affect the bits sent.
- R10: `read_all_o` pulses for one cycle after the sixteenth result bit. If the master answers the first byte with NAK, the slave releases the line and no pulse follows.
- R11: `txn_end_o` pulses for one cycle at a stop that follows at least one acknowledged address since the previous stop. This includes a write with no data byte, which leaves `mode_o` unchanged. A stop after only refused addresses gives no pulse.
- R12: A repeated start after a completed write lets a read follow in the same transaction, and the written mode is already in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (as seen on the wire) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| conv_busy_i | input | 1 | Conversion in progress; addressing is refused |
| result_i | input | RES_W (16) | Latest conversion result, held by the sequencer |
| mode_o | output | 1 | Speed-select bit from the last accepted write byte |
| txn_end_o | output | 1 | One-cycle pulse at a stop closing an acknowledged transaction |
| read_all_o | output | 1 | One-cycle pulse after the last result bit is sent |

## Verification
A wrong internal state shows up almost at once on `sda_oe_o`. A miscounted bit moves the acknowledge to the wrong clock. A bad address decision turns an ACK into a NAK. A slipped read shift register corrupts the next bit the master samples. In every case the error is visible within one SCL period, three system clocks after the falling edge that triggers it. Errors in the mode or event logic appear only at the end of a byte or at a stop, so the bench compares `mode_o` every cycle and compares the event-pulse counts after each transaction.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } i2cr_state_e;
endpackage

// File: rtl/i2cr_sync.sv
// Multi-stage synchronizer with one extra history stage for edge detection.
module i2cr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/i2cr_evt.sv
// Bus event decode from synchronized current and previous samples.
module i2cr_evt (
  input  logic scl_q,
  input  logic scl_p,
  input  logic sda_q,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_held;
  assign scl_held = scl_q & scl_p;
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_held & sda_p & ~sda_q;
  assign stop_ev  = scl_held & ~sda_p & sda_q;
endmodule

// File: rtl/i2cr_proto.sv
// Byte-level protocol engine: address match, busy refusal, config write, result read.
module i2cr_proto
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b0010100,
  parameter logic [6:0] BCAST_ADDR = 7'b1110111,
  parameter int         RES_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_q,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic             mode,
  output logic             sda_oe,
  output logic             txn_end,
  output logic             read_all,
  output i2cr_state_e      st
);
  localparam int NBYTES = RES_W / 8;
  localparam int BW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BW-1:0] LAST_BYTE = BW'(NBYTES - 1);

  logic [7:0]       sh;
  logic [3:0]       cnt;
  logic [BW-1:0]    byte_idx;
  logic [RES_W-1:0] obuf;
  logic             rd, acked, mack, hit;

  assign hit = !busy && ((sh[7:1] == DEV_ADDR) || ((sh[7:1] == BCAST_ADDR) && !sh[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      byte_idx <= '0;
      obuf     <= '0;
      rd       <= 1'b0;
      acked    <= 1'b0;
      mack     <= 1'b1;
      mode     <= 1'b0;
      sda_oe   <= 1'b0;
      txn_end  <= 1'b0;
      read_all <= 1'b0;
    end else begin
      txn_end  <= 1'b0;
      read_all <= 1'b0;
      if (stop_ev) begin
        txn_end <= acked;
        acked   <= 1'b0;
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ST_WDATA) begin
                sda_oe <= 1'b1;
                st     <= ST_WACK;
              end else if (hit) begin
                sda_oe <= 1'b1;
                st     <= ST_AACK;
                rd     <= sh[0];
                acked  <= 1'b1;
                obuf   <= result;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt      <= '0;
            byte_idx <= '0;
            if (rd) begin
              st     <= ST_RDATA;
              sda_oe <= ~obuf[RES_W-1];
            end else begin
              st     <= ST_WDATA;
              sda_oe <= 1'b0;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            mode   <= sh[0];
            st     <= ST_IDLE;
          end
          ST_RDATA: if (scl_fall) begin
            obuf <= obuf << 1;
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (byte_idx == LAST_BYTE) begin
                read_all <= 1'b1;
                st       <= ST_IDLE;
              end else begin
                st <= ST_RACK;
              end
            end else begin
              sda_oe <= ~obuf[RES_W-2];
              cnt    <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= sda_q;
            else if (scl_fall) begin
              if (!mack) begin
                st       <= ST_RDATA;
                sda_oe   <= ~obuf[RES_W-1];
                byte_idx <= byte_idx + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b0010100,
  parameter logic [6:0] BCAST_ADDR = 7'b1110111,
  parameter int         RES_W      = 16,
  parameter int         SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             conv_busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic             mode_o,
  output logic             txn_end_o,
  output logic             read_all_o
);
  logic [1:0]  ln_q, ln_p;
  logic        scl_s, scl_rise, scl_fall, start_ev, stop_ev;
  i2cr_state_e st;

  i2cr_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(ln_q), .q_prev(ln_p)
  );

  assign scl_s = ln_q[1];

  i2cr_evt u_evt (
    .scl_q(ln_q[1]), .scl_p(ln_p[1]), .sda_q(ln_q[0]), .sda_p(ln_p[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cr_proto #(.DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR), .RES_W(RES_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_q(ln_q[0]),
    .start_ev(start_ev), .stop_ev(stop_ev), .busy(conv_busy_i), .result(result_i),
    .mode(mode_o), .sda_oe(sda_oe_o), .txn_end(txn_end_o), .read_all(read_all_o), .st(st)
  );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
  import i2cr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        conv_busy,
  input logic        mode,
  input logic        read_all,
  input logic        txn_end,
  input i2cr_state_e st
);
  AST_ACK_ONLY_IDLE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st == ST_AACK) |-> !$past(conv_busy)); // R6
  AST_PULL_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9
  AST_MODE_AFTER_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(st) == ST_WACK); // R7
  AST_READALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    read_all |=> !read_all); // R10
  AST_TXNEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> !txn_end); // R11
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({read_all, txn_end})); // R10
endmodule

bind adc_i2c_slave i2cr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .conv_busy(conv_busy_i),
  .mode(mode_o), .read_all(read_all_o), .txn_end(txn_end_o), .st(st)
);

// File: tb/adc_i2c_slave_tb.sv
module adc_i2c_slave_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, scl, m_sda, busy;
  logic [15:0] res, cap;
  logic        sda_oe, mode, txn_end, read_all;
  wire         sda_bus = m_sda & ~sda_oe;

  int    checks = 0, fails = 0, settle = 0;
  int    n_ra = 0, n_te = 0, e_ra = 0, e_te = 0;
  logic  exp_oe = 1'b0, exp_mode = 1'b0, acked_model = 1'b0;
  string cur_req = "R1";

  adc_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .conv_busy_i(busy), .result_i(res), .mode_o(mode), .txn_end_o(txn_end),
    .read_all_o(read_all)
  );

  always @(posedge clk) settle = settle + 1;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural model once the lines have settled
  always @(negedge clk) begin
    if (rst_n) begin
      if (read_all) n_ra++;
      if (txn_end)  n_te++;
      if (settle >= 4) begin
        chk(sda_oe === exp_oe, cur_req, "sda_oe per-cycle", sda_oe, exp_oe);
        chk(mode === exp_mode, cur_req, "mode per-cycle", mode, exp_mode);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, input logic after, output logic r);
    wt(4); m_sda = b;
    wt(6); scl = 1'b1; settle = 0;
    wt(5); r = sda_bus;
    wt(5); scl = 1'b0; exp_oe = after; settle = 0;
  endtask

  task automatic bstart();
    wt(4); m_sda = 1'b1;
    wt(6); scl = 1'b1; settle = 0;
    wt(6); m_sda = 1'b0; settle = 0;
    wt(6); scl = 1'b0; exp_oe = 1'b0; settle = 0;
  endtask

  task automatic bstop();
    wt(4); m_sda = 1'b0;
    wt(6); scl = 1'b1; settle = 0;
    wt(6); m_sda = 1'b1; exp_oe = 1'b0; settle = 0;
    if (acked_model) e_te++;
    acked_model = 1'b0;
    wt(10);
    chk(n_te == e_te, "R11", "txn_end pulse count", n_te, e_te);
    chk(n_ra == e_ra, "R10", "read_all pulse count", n_ra, e_ra);
  endtask

  task automatic addr(input logic [6:0] a, input logic rw, input string rq);
    logic r, ack;
    logic [7:0] by;
    by  = {a, rw};
    ack = !busy && (a == 7'b0010100 || (a == 7'b1110111 && !rw));
    for (int i = 7; i >= 0; i--) xbit(by[i], (i == 0) ? ack : 1'b0, r);
    if (ack && rw) cap = res;
    xbit(1'b1, (ack && rw) ? ~cap[15] : 1'b0, r);
    chk(r == !ack, rq, "address acknowledge level", r, !ack);
    if (ack) acked_model = 1'b1;
  endtask

  task automatic wbyte(input logic [7:0] d, input logic ack, input string rq);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(d[i], (i == 0) ? ack : 1'b0, r);
    xbit(1'b1, 1'b0, r);
    if (ack) exp_mode = d[0];
    chk(r == !ack, rq, "data byte acknowledge level", r, !ack);
  endtask

  task automatic rbytes(input logic mack, input string rq);
    logic r;
    for (int i = 15; i >= 8; i--) begin
      xbit(1'b1, (i == 8) ? 1'b0 : ~cap[(i == 8) ? 8 : i - 1], r);
      chk(r == cap[i], rq, "result bit", r, cap[i]);
    end
    xbit(mack ? 1'b0 : 1'b1, mack ? ~cap[7] : 1'b0, r);
    if (mack) begin
      for (int i = 7; i >= 0; i--) begin
        xbit(1'b1, (i == 0) ? 1'b0 : ~cap[(i == 0) ? 0 : i - 1], r);
        chk(r == cap[i], rq, "result bit", r, cap[i]);
      end
      e_ra++;
      xbit(1'b1, 1'b0, r);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    logic r;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; busy = 1'b0; res = 16'hA55A; cap = '0;
    wt(5);
    chk(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
    chk(mode == 1'b0, "R1", "mode in reset", mode, 0);
    rst_n = 1'b1;
    wt(10);
    chk(n_ra == 0 && n_te == 0, "R1", "no events after reset", n_ra + n_te, 0);

    cur_req = "R3"; bstart(); addr(7'b0010100, 1'b1, "R3");
    cur_req = "R9"; rbytes(1'b1, "R9"); bstop();

    cur_req = "R9"; res = 16'h3C81; bstart(); addr(7'b0010100, 1'b1, "R9");
    res = 16'hFFFF; rbytes(1'b1, "R9"); bstop();

    cur_req = "R6"; busy = 1'b1; bstart(); addr(7'b0010100, 1'b1, "R6"); bstop(); busy = 1'b0;
    busy = 1'b1; bstart(); addr(7'b0010100, 1'b0, "R6"); bstop(); busy = 1'b0;

    cur_req = "R5"; bstart(); addr(7'b0110011, 1'b0, "R5"); wbyte(8'h01, 1'b0, "R5"); bstop();
    chk(mode == 1'b0, "R5", "mode after refused address", mode, 0);

    cur_req = "R7"; bstart(); addr(7'b0010100, 1'b0, "R7"); wbyte(8'h01, 1'b1, "R7");
    wbyte(8'h00, 1'b0, "R7"); bstop();
    chk(mode == 1'b1, "R7", "mode after write", mode, 1);

    cur_req = "R4"; bstart(); addr(7'b1110111, 1'b0, "R4"); wbyte(8'hFE, 1'b1, "R4"); bstop();
    chk(mode == 1'b0, "R4", "mode after broadcast write", mode, 0);
    bstart(); addr(7'b1110111, 1'b1, "R4"); bstop();

    cur_req = "R11"; bstart(); addr(7'b1110111, 1'b0, "R11"); bstop();
    chk(mode == 1'b0, "R11", "mode after empty write", mode, 0);

    cur_req = "R8"; bstart(); addr(7'b0010100, 1'b0, "R8");
    for (int i = 0; i < 4; i++) xbit(1'b1, 1'b0, r);
    bstop();
    chk(mode == 1'b0, "R8", "mode after aborted byte", mode, 0);

    cur_req = "R2"; res = 16'h1234; bstart(); addr(7'b0010100, 1'b0, "R2");
    for (int i = 0; i < 3; i++) xbit(1'b1, 1'b0, r);
    bstart(); addr(7'b0010100, 1'b1, "R2"); rbytes(1'b1, "R2"); bstop();
    chk(mode == 1'b0, "R2", "mode after restarted byte", mode, 0);

    cur_req = "R12"; res = 16'h8001; bstart(); addr(7'b0010100, 1'b0, "R12");
    wbyte(8'h01, 1'b1, "R12");
    bstart(); addr(7'b0010100, 1'b1, "R12");
    chk(mode == 1'b1, "R12", "mode before read", mode, 1);
    rbytes(1'b1, "R12"); bstop();

    cur_req = "R10"; res = 16'h7E00; bstart(); addr(7'b0010100, 1'b1, "R10");
    rbytes(1'b0, "R10"); bstop();

    wt(20);
    report();
    $finish;
  end
endmodule